// File: doc/BRIEF.md
# Write-Protection Command Sequencer

This block sits between the decoded write path of a page-programmed non-volatile memory and its write controller. Every accepted write event (address and data) is also compared against two fixed command sequences: a short unlock/enable sequence and a longer disable sequence. Writes that belong to a command are flagged so that the controller leaves them out of the page buffer. Every other write is flagged as user data.

When the load window closes (`load_timeout_i`), the block issues one commit pulse and states whether the array may be programmed. It then holds itself busy for one programming period. A completed enable sequence arms protection and a completed disable sequence clears it. Either change lands in the cycle that ends that programming period. While protection is set, a load is allowed to program only if its first writes are the enable sequence. A load without that prefix still runs the programming period but is reported as blocked. A command sequence counts only when it starts at the first write of a load. The command addresses, data values and sequence lengths are parameters.

Write events use valid/ready. `wr_ready_o` is low for the whole programming period and in any cycle where `load_timeout_i` is high. A source must hold `wr_valid_i`, address and data until it sees ready. Protection, commit and status pins are plain signals. `rst_ni` sets the delivery state of the protect flag (`PROTECT_INIT`, default clear). Nothing else clears the flag except the disable sequence.

Top module: `wp_guard`

## Requirements
- R1: After reset, `protect_o` = 0, `prog_busy_o` = 0, `commit_o` = 0, `cmd_active_o` = 0 and `wr_ready_o` = 1.
- R2: A write is accepted in a cycle with `wr_valid_i` = 1 and `wr_ready_o` = 1. `wr_ready_o` is 0 while `prog_busy_o` = 1 and in any cycle with `load_timeout_i` = 1.
- R3: The enable sequence is (0x1555,0xAA), (0x0AAA,0x55), (0x1555,0xA0), given as (address,data) in order. A load that begins with it sets `protect_o` exactly PROG_CYCLES clock edges after the edge that sampled the closing timeout. `protect_o` does not change at any other time.
- R4: A timeout while a load is open gives `commit_o` = 1 for exactly the next cycle. It also gives `prog_busy_o` = 1 for PROG_CYCLES cycles. A timeout with no open load has no effect.
- R5: While protected, a load without the enable prefix gives `commit_en_o` = 0 with its commit. The programming period still runs and `protect_o` stays 1.
- R6: While protected, a load that begins with the enable sequence gives `commit_en_o` = 1, and `protect_o` stays 1.
- R7: The disable sequence is (0x1555,0xAA), (0x0AAA,0x55), (0x1555,0x80), (0x1555,0xAA), (0x0AAA,0x55), (0x1555,0x20). A load that begins with it gives `commit_en_o` = 1 and clears `protect_o` at the end of its programming period.
- R8: `wr_keep_o` is 0 for an accepted write that matches the next step of a live sequence, and 1 for every other accepted write. This includes a write to a command address made after its sequence has completed.
- R9: A write that does not match the next step ends that sequence for the rest of the load. That write is kept, and the load counts as an ordinary load.
- R10: `cmd_active_o` is 1 once at least one step, but not all steps, of a live sequence has matched. It is 0 after completion, after a mismatch and after the load closes.
- R11: A command sequence counts only from the first write of a load. Any earlier user write disables both sequences for that load.
- R12: While unprotected, every load commits with `commit_en_o` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset, sets the delivery state |
| wr_valid_i | input | 1 | Write event present |
| wr_ready_o | output | 1 | Write event may be accepted this cycle |
| wr_addr_i | input | ADDR_W | Write address |
| wr_data_i | input | DATA_W | Write data |
| wr_keep_o | output | 1 | Accepted write is user data (not a command byte) |
| load_timeout_i | input | 1 | Load window closed |
| commit_o | output | 1 | One-cycle pulse: a programming period starts |
| commit_en_o | output | 1 | With commit_o: the array may be changed |
| prog_busy_o | output | 1 | Programming period running |
| protect_o | output | 1 | Protection state |
| cmd_active_o | output | 1 | A command sequence is partly matched |

## Verification
A sequence tracker stuck at a wrong step shows up as a wrong `wr_keep_o` on the very write that should have matched. It also shows up on `cmd_active_o` one cycle later. A wrong protect decision first shows up on `commit_en_o` in the cycle after the timeout. A wrong flag update shows up on `protect_o` exactly PROG_CYCLES edges later, and on every commit after that. A timer of the wrong length shows up as `wr_ready_o` and `prog_busy_o` releasing one or more cycles early or late.

// File: rtl/wp_pkg.sv
package wp_pkg;
  localparam int WP_ADDR_W = 13;
  localparam int WP_DATA_W = 8;
  localparam int WP_ENA_LEN = 3;
  localparam int WP_DIS_LEN = 6;
  // step 0 sits in the least significant slice
  localparam logic [WP_ENA_LEN*WP_ADDR_W-1:0] WP_ENA_ADDRS = {13'h1555, 13'h0AAA, 13'h1555};
  localparam logic [WP_ENA_LEN*WP_DATA_W-1:0] WP_ENA_DATAS = {8'hA0, 8'h55, 8'hAA};
  localparam logic [WP_DIS_LEN*WP_ADDR_W-1:0] WP_DIS_ADDRS =
    {13'h1555, 13'h0AAA, 13'h1555, 13'h1555, 13'h0AAA, 13'h1555};
  localparam logic [WP_DIS_LEN*WP_DATA_W-1:0] WP_DIS_DATAS =
    {8'h20, 8'h55, 8'hAA, 8'h80, 8'h55, 8'hAA};

  typedef enum logic [1:0] {
    PACT_HOLD  = 2'd0,
    PACT_SET   = 2'd1,
    PACT_CLEAR = 2'd2
  } prot_act_e;
endpackage

// File: rtl/wp_seq_track.sv
module wp_seq_track #(
  parameter int AW  = 13,
  parameter int DW  = 8,
  parameter int LEN = 3,
  parameter logic [LEN*AW-1:0] ADDRS = '0,
  parameter logic [LEN*DW-1:0] DATAS = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          step_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic          hit_o,
  output logic          done_o,
  output logic          mid_o
);
  localparam int IW = $clog2(LEN + 1);

  logic [IW-1:0] idx_q;
  logic          dead_q;
  logic [IW-1:0] idx_sel;
  logic [AW-1:0] want_addr;
  logic [DW-1:0] want_data;
  logic          match;

  assign done_o    = (idx_q == IW'(LEN));
  assign idx_sel   = done_o ? '0 : idx_q;
  assign want_addr = ADDRS[int'(idx_sel)*AW +: AW];
  assign want_data = DATAS[int'(idx_sel)*DW +: DW];
  assign match     = (addr_i == want_addr) && (data_i == want_data);
  assign hit_o     = step_i && !dead_q && !done_o && match;
  assign mid_o     = !dead_q && !done_o && (idx_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      dead_q <= 1'b0;
    end else if (clear_i) begin
      idx_q  <= '0;
      dead_q <= 1'b0;
    end else if (step_i) begin
      if (hit_o) begin
        idx_q <= idx_q + 1'b1;
      end else if (!done_o) begin
        dead_q <= 1'b1;
      end
    end
  end

  AST_DONE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !clear_i |=> done_o); // R8
  AST_IDX_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_q <= IW'(LEN)); // R10
  AST_DEAD_STAYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dead_q && !clear_i |=> !hit_o && !mid_o); // R9
endmodule

// File: rtl/wp_prog_timer.sv
module wp_prog_timer #(
  parameter int CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic last_o
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt_q;

  assign busy_o = (cnt_q != '0);
  assign last_o = (cnt_q == CW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (start_i) begin
      cnt_q <= CW'(CYCLES);
    end else if (busy_o) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  AST_START_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_o); // R4
  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(CYCLES)); // R4
endmodule

// File: rtl/wp_guard.sv
module wp_guard
  import wp_pkg::*;
#(
  parameter int ADDR_W       = WP_ADDR_W,
  parameter int DATA_W       = WP_DATA_W,
  parameter int PROG_CYCLES  = 16,
  parameter bit PROTECT_INIT = 1'b0,
  parameter int ENA_LEN      = WP_ENA_LEN,
  parameter int DIS_LEN      = WP_DIS_LEN,
  parameter logic [ENA_LEN*ADDR_W-1:0] ENA_ADDRS = WP_ENA_ADDRS,
  parameter logic [ENA_LEN*DATA_W-1:0] ENA_DATAS = WP_ENA_DATAS,
  parameter logic [DIS_LEN*ADDR_W-1:0] DIS_ADDRS = WP_DIS_ADDRS,
  parameter logic [DIS_LEN*DATA_W-1:0] DIS_DATAS = WP_DIS_DATAS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  output logic              wr_ready_o,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              wr_keep_o,
  input  logic              load_timeout_i,
  output logic              commit_o,
  output logic              commit_en_o,
  output logic              prog_busy_o,
  output logic              protect_o,
  output logic              cmd_active_o
);
  logic      accept;
  logic      load_open_q;
  logic      load_end;
  logic      en_hit, en_done, en_mid;
  logic      dis_hit, dis_done, dis_mid;
  logic      tmr_last;
  logic      protect_q;
  logic      commit_q, commit_en_q;
  logic      allow;
  prot_act_e act_d, act_q;

  assign wr_ready_o = !prog_busy_o && !load_timeout_i;
  assign accept     = wr_valid_i && wr_ready_o;
  assign load_end   = load_timeout_i && load_open_q;

  wp_seq_track #(
    .AW(ADDR_W), .DW(DATA_W), .LEN(ENA_LEN), .ADDRS(ENA_ADDRS), .DATAS(ENA_DATAS)
  ) u_ena_track (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(load_end), .step_i(accept),
    .addr_i(wr_addr_i), .data_i(wr_data_i),
    .hit_o(en_hit), .done_o(en_done), .mid_o(en_mid)
  );

  wp_seq_track #(
    .AW(ADDR_W), .DW(DATA_W), .LEN(DIS_LEN), .ADDRS(DIS_ADDRS), .DATAS(DIS_DATAS)
  ) u_dis_track (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(load_end), .step_i(accept),
    .addr_i(wr_addr_i), .data_i(wr_data_i),
    .hit_o(dis_hit), .done_o(dis_done), .mid_o(dis_mid)
  );

  wp_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(load_end),
    .busy_o(prog_busy_o), .last_o(tmr_last)
  );

  assign wr_keep_o    = accept && !en_hit && !dis_hit;
  assign cmd_active_o = en_mid || dis_mid;

  // disable sequence takes precedence if both were ever configured to complete
  always_comb begin
    if (dis_done)     act_d = PACT_CLEAR;
    else if (en_done) act_d = PACT_SET;
    else              act_d = PACT_HOLD;
  end
  assign allow = dis_done || en_done || !protect_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      load_open_q <= 1'b0;
      commit_q    <= 1'b0;
      commit_en_q <= 1'b0;
      act_q       <= PACT_HOLD;
      protect_q   <= PROTECT_INIT;
    end else begin
      commit_q    <= load_end;
      commit_en_q <= load_end && allow;
      if (load_end)    load_open_q <= 1'b0;
      else if (accept) load_open_q <= 1'b1;
      if (load_end) act_q <= act_d;
      if (tmr_last) begin
        if (act_q == PACT_SET)        protect_q <= 1'b1;
        else if (act_q == PACT_CLEAR) protect_q <= 1'b0;
      end
    end
  end

  assign commit_o    = commit_q;
  assign commit_en_o = commit_en_q;
  assign protect_o   = protect_q;

  AST_COMMIT_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |=> !commit_o); // R4
  AST_COMMIT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> prog_busy_o); // R4
  AST_BLOCK_NEEDS_PROT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o && !commit_en_o |-> protect_o); // R5
  AST_PROT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !prog_busy_o |=> $stable(protect_o)); // R3
  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_busy_o |-> !wr_ready_o); // R2
  AST_KEEP_ON_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_keep_o |-> wr_valid_i && wr_ready_o); // R8
  AST_CMD_IDLE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> !cmd_active_o); // R10
endmodule

// File: tb/wp_guard_tb.sv
module wp_guard_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PROG = 16;

  localparam logic [12:0] EA [3] = '{13'h1555, 13'h0AAA, 13'h1555};
  localparam logic [7:0]  ED [3] = '{8'hAA, 8'h55, 8'hA0};
  localparam logic [12:0] DA [6] = '{13'h1555, 13'h0AAA, 13'h1555, 13'h1555, 13'h0AAA, 13'h1555};
  localparam logic [7:0]  DD [6] = '{8'hAA, 8'h55, 8'h80, 8'hAA, 8'h55, 8'h20};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0;
  logic [12:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic load_timeout = 1'b0;
  logic wr_ready, wr_keep, commit, commit_en, prog_busy, protect, cmd_active;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  int m_en_idx, m_dis_idx;
  bit m_en_dead, m_dis_dead, m_prot;

  always #(CLK_PERIOD/2) clk = ~clk;

  wp_guard #(.PROG_CYCLES(PROG)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_valid_i(wr_valid), .wr_ready_o(wr_ready),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .wr_keep_o(wr_keep),
    .load_timeout_i(load_timeout),
    .commit_o(commit), .commit_en_o(commit_en),
    .prog_busy_o(prog_busy), .protect_o(protect), .cmd_active_o(cmd_active)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit exp_cmd_active();
    return (!m_en_dead && m_en_idx > 0 && m_en_idx < 3) ||
           (!m_dis_dead && m_dis_idx > 0 && m_dis_idx < 6);
  endfunction

  task automatic model_clear();
    m_en_idx = 0; m_dis_idx = 0; m_en_dead = 0; m_dis_dead = 0;
  endtask

  // one accepted write; checks keep flag (R8, R9, R11) and cmd_active (R10)
  task automatic wr(input logic [12:0] a, input logic [7:0] d);
    bit eh, dh;
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    #1;
    eh = !m_en_dead && m_en_idx < 3 && a == EA[m_en_idx] && d == ED[m_en_idx];
    dh = !m_dis_dead && m_dis_idx < 6 && a == DA[m_dis_idx] && d == DD[m_dis_idx];
    chk(wr_ready == 1'b1, "R2 ready when idle", wr_ready, 1);
    chk(wr_keep == !(eh || dh), "R8 keep flag", wr_keep, !(eh || dh));
    if (eh) m_en_idx++; else if (m_en_idx < 3) m_en_dead = 1;
    if (dh) m_dis_idx++; else if (m_dis_idx < 6) m_dis_dead = 1;
    @(negedge clk);
    wr_valid = 1'b0;
    chk(cmd_active == exp_cmd_active(), "R10 cmd_active", cmd_active, exp_cmd_active());
  endtask

  // close the load and follow the programming period (R3 R4 R5 R6 R7 R12)
  task automatic end_load();
    bit en_ok, newp, oldp;
    oldp  = m_prot;
    en_ok = (m_dis_idx == 6) || (m_en_idx == 3) || !m_prot;
    newp  = (m_dis_idx == 6) ? 1'b0 : (m_en_idx == 3) ? 1'b1 : m_prot;
    @(negedge clk);
    load_timeout = 1'b1;
    #1;
    chk(wr_ready == 1'b0, "R2 ready low on timeout", wr_ready, 0);
    @(negedge clk);
    load_timeout = 1'b0;
    chk(commit == 1'b1, "R4 commit pulse", commit, 1);
    chk(commit_en == en_ok, "R5/R6/R7/R12 commit_en", commit_en, en_ok);
    chk(prog_busy == 1'b1, "R4 busy after commit", prog_busy, 1);
    chk(cmd_active == 1'b0, "R10 cmd_active after close", cmd_active, 0);
    model_clear();
    @(negedge clk);
    chk(commit == 1'b0, "R4 commit single cycle", commit, 0);
    chk(wr_ready == 1'b0, "R2 ready low while busy", wr_ready, 0);
    repeat (PROG - 2) @(negedge clk);
    chk(protect == oldp, "R3 protect before period end", protect, oldp);
    chk(prog_busy == 1'b1, "R4 busy to last cycle", prog_busy, 1);
    @(negedge clk);
    chk(protect == newp, "R3/R7 protect after period", protect, newp);
    chk(prog_busy == 1'b0, "R4 busy released", prog_busy, 0);
    m_prot = newp;
  endtask

  task automatic send_enable();
    for (int i = 0; i < 3; i++) wr(EA[i], ED[i]);
  endtask

  task automatic send_disable();
    for (int i = 0; i < 6; i++) wr(DA[i], DD[i]);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'h5EED1234);
    model_clear();
    m_prot = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(protect == 1'b0, "R1 protect", protect, 0);
    chk(prog_busy == 1'b0, "R1 busy", prog_busy, 0);
    chk(commit == 1'b0, "R1 commit", commit, 0);
    chk(cmd_active == 1'b0, "R1 cmd_active", cmd_active, 0);
    chk(wr_ready == 1'b1, "R1 ready", wr_ready, 1);

    // R12 plain load while unprotected
    wr(13'h0100, 8'h3C);
    wr(13'h0101, 8'h3D);
    end_load();

    // R4 timeout without an open load is ignored
    @(negedge clk); load_timeout = 1'b1;
    @(negedge clk); load_timeout = 1'b0;
    chk(commit == 1'b0, "R4 idle timeout no commit", commit, 0);
    chk(prog_busy == 1'b0, "R4 idle timeout no busy", prog_busy, 0);

    // R3 enable sequence plus data
    send_enable();
    wr(13'h0200, 8'h11);
    end_load();
    chk(protect == 1'b1, "R3 protect set", protect, 1);

    // R5 unprefixed write while protected
    wr(13'h0300, 8'h22);
    end_load();
    chk(protect == 1'b1, "R5 protect held", protect, 1);

    // R6 prefixed write; R8 command address with its data after completion is kept
    send_enable();
    wr(13'h1555, 8'hAA);
    end_load();

    // R9 mismatch at step two
    wr(13'h1555, 8'hAA);
    wr(13'h0AAA, 8'h56);
    chk(cmd_active == 1'b0, "R9 sequence dropped", cmd_active, 0);
    wr(13'h1555, 8'hA0);
    end_load();

    // R11 user write before the sequence
    wr(13'h0400, 8'h77);
    send_enable();
    end_load();
    chk(protect == 1'b1, "R11 protect unchanged", protect, 1);

    // R7 disable
    send_disable();
    wr(13'h0500, 8'h99);
    end_load();
    chk(protect == 1'b0, "R7 protect cleared", protect, 0);

    // random loads
    for (int n = 0; n < 60; n++) begin
      int kind, nd;
      kind = int'($urandom % 5);
      case (kind)
        1: send_enable();
        2: send_disable();
        3: begin wr(EA[0], ED[0]); wr(EA[1], ED[1]); end
        4: begin
             wr(DA[0], DD[0]); wr(DA[1], DD[1]); wr(DA[2], DD[2]);
           end
        default: ;
      endcase
      nd = (kind == 0) ? 1 + int'($urandom % 3) : int'($urandom % 3);
      for (int k = 0; k < nd; k++) begin
        logic [12:0] ra;
        logic [7:0]  rd;
        ra = 13'($urandom);
        rd = 8'($urandom);
        if ($urandom % 4 == 0) ra = 13'h1555;
        wr(ra, rd);
      end
      end_load();
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule